// File: doc/BRIEF.md
# Sparse-Output Windowed Bandpass FIR Filter

This block is a 264-tap linear-phase FIR filter that produces only a small set of filtered samples per observation window, not a continuous output stream. The wanted outputs fall on adjacent sample instants at the start of the window. The block keeps one accumulator per wanted output. As each input sample arrives, the block weights it with the coefficient that output needs at that instant and adds it into the accumulator. The convolution is therefore spread over the collection interval, and no full-length delay line of input samples is kept.

The coefficients are symmetric, so only the first half of the impulse response is stored. The memory is read once per sample. A short coefficient delay line, one stage per accumulator, hands each coefficient on to the next accumulator on the following sample. A single multiply-accumulate datapath walks the active accumulators one per clock after each sample. A window-start pulse clears all accumulators and restarts the sample count. Finished results leave through a valid/ready port in ascending output order.

Top module: `sfir_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, `res_valid`, `overrun` and `dropped` are low.
- R2: Coefficient entry e (0..131) is written through `cf_we`/`cf_addr`/`cf_data`. Tap t uses entry t for t < 132 and entry 263−t for t ≥ 132. A write with `cf_addr` ≥ 132 changes no entry.
- R3: With x[n] the n-th sample accepted since the last window start (n from 0), result k equals the running saturating sum over t = 0..263, in increasing t, of P(x[k+t], h[t]).
- R4: The product P(a,b) equals floor(a·b / 32768), clamped to [−32768, 32767]. Negative products round toward minus infinity, and (−32768)·(−32768) gives 32767.
- R5: Each accumulation step saturates at 32767 and −32768 instead of wrapping.
- R6: `out_count` is sampled at each window start and clamped to the range 3..10. Exactly that many results are delivered per window, with `res_idx` always below it.
- R7: Results appear in ascending `res_idx` order, starting at 0, under a valid/ready handshake. While `res_valid` is high and `res_ready` is low, `res_data` and `res_idx` hold steady.
- R8: Result k becomes available only after sample index k+263 has been accepted. It is presented within `out_count`+1 clocks of that sample's strobe.
- R9: After an accepted sample, the block is busy for `out_count` clocks. A sample strobe during that time is ignored and sets the sticky `overrun` flag.
- R10: A window start while a result is still unread discards all unread results. `res_valid` is then low on the next clock, and the sticky `dropped` flag is set.
- R11: A window start clears all accumulators and the sample count. A sample strobe in the same cycle as a window start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | Window start: clears accumulators and samples `out_count` |
| out_count | input | 4 | Number of wanted outputs (clamped to 3..10) |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | 8 | Coefficient entry address (0..131 valid) |
| cf_data | input | 16 | Signed coefficient value, fraction scaled by 2^15 |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed input sample |
| res_valid | output | 1 | A finished result is presented |
| res_ready | input | 1 | Consumer accepts the presented result |
| res_data | output | 16 | Signed filtered result |
| res_idx | output | 4 | Output index of the presented result |
| overrun | output | 1 | Sticky: a sample arrived while the datapath was busy |
| dropped | output | 1 | Sticky: unread results were discarded by a window start |

## Verification
The bench runs each accumulator through both saturation limits and through the extreme product (−32768)·(−32768). A datapath that wrapped would return a value of the opposite sign. Rounding that truncates toward zero would turn a window of −1·(1/32768) products into 0 instead of −264. Clamped output counts, writes past the stored half, and a strobe that lands in the busy window or on a window start each show up as a wrong result count or shifted data. The bench checks the first result's timing against the 264th sample, the stability of held results, and the loss of unread results on a window start, each at the ports.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  localparam int SFIR_W    = 16;
  localparam int SFIR_TAPS = 264;
  localparam int SFIR_MAXO = 10;
  localparam int SFIR_MINO = 3;

  typedef logic signed [SFIR_W-1:0]   smp_t;
  typedef logic signed [2*SFIR_W-1:0] wide_t;

  localparam wide_t POS_LIM = wide_t'((2**(SFIR_W-1)) - 1);
  localparam wide_t NEG_LIM = -wide_t'(2**(SFIR_W-1));

  // clamp a wide value into the sample range
  function automatic smp_t clamp_w(input wide_t v);
    if (v > POS_LIM)      return smp_t'(POS_LIM);
    else if (v < NEG_LIM) return smp_t'(NEG_LIM);
    else                  return smp_t'(v);
  endfunction

  // fractional multiply: arithmetic shift floors, then clamp
  function automatic smp_t q_mul(input smp_t a, input smp_t b);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    return clamp_w(p >>> (SFIR_W - 1));
  endfunction

  // saturating add of two samples
  function automatic smp_t sat_add(input smp_t a, input smp_t b);
    wide_t s;
    s = wide_t'(a) + wide_t'(b);
    return clamp_w(s);
  endfunction
endpackage

// File: rtl/sfir_coef_store.sv
module sfir_coef_store import sfir_pkg::*; #(
  parameter int TAPS = SFIR_TAPS,
  parameter int HALF = TAPS / 2,
  parameter int AW   = $clog2(HALF),
  parameter int NW   = $clog2(TAPS + SFIR_MAXO + 1)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  smp_t          wdata,
  input  logic [NW-1:0] rtap,
  output smp_t          rdata
);
  smp_t          mem [HALF];
  logic [AW-1:0] ridx;
  logic          in_range;

  // writes beyond the stored half are discarded
  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < (AW+1)'(HALF)))
      mem[waddr] <= wdata;
  end

  // mirror the upper half of the taps onto the stored half
  always_comb begin
    in_range = 1'b1;
    if (rtap < NW'(HALF))
      ridx = rtap[AW-1:0];
    else if (rtap < NW'(TAPS))
      ridx = AW'(NW'(TAPS - 1) - rtap);
    else begin
      ridx     = '0;
      in_range = 1'b0;
    end
    rdata = in_range ? mem[ridx] : '0;
  end
endmodule

// File: rtl/sfir_mac_seq.sv
module sfir_mac_seq import sfir_pkg::*; #(
  parameter int TAPS    = SFIR_TAPS,
  parameter int MAX_OUT = SFIR_MAXO,
  parameter int MIN_OUT = SFIR_MINO,
  parameter int IW      = $clog2(MAX_OUT + 1),
  parameter int NW      = $clog2(TAPS + MAX_OUT + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          win_start,
  input  logic                          smp_valid,
  input  smp_t                          smp_data,
  input  logic [IW-1:0]                 cnt_cfg,
  input  smp_t                          coef_in,
  output logic [NW-1:0]                 tap_cur,
  output logic                          busy,
  output logic                          fin_valid,
  output logic [IW-1:0]                 fin_idx,
  output logic [IW-1:0]                 cnt_q,
  output logic                          overrun,
  output logic [MAX_OUT-1:0][SFIR_W-1:0] acc_o
);
  localparam logic [NW-1:0] N_SAT = NW'(TAPS + MAX_OUT);

  logic [NW-1:0]      n_q;
  smp_t               x_q;
  smp_t               line_c [MAX_OUT];
  logic [MAX_OUT-1:0] line_v, line_l;
  logic [IW-1:0]      k_q, cnt_r;
  logic               busy_q, ovr_q;
  smp_t               acc_r [MAX_OUT];

  // named internal events
  logic take_evt, ovr_evt, mac_en, cur_v, cur_l;
  smp_t cur_c, mac_sum;

  function automatic logic [IW-1:0] clamp_cnt(input logic [IW-1:0] c);
    if (c < IW'(MIN_OUT))      return IW'(MIN_OUT);
    else if (c > IW'(MAX_OUT)) return IW'(MAX_OUT);
    else                       return c;
  endfunction

  assign take_evt  = smp_valid && !busy_q && !win_start;
  assign ovr_evt   = smp_valid &&  busy_q && !win_start;
  assign mac_en    = busy_q && !win_start;
  assign cur_v     = line_v[k_q];
  assign cur_l     = line_l[k_q];
  assign cur_c     = line_c[k_q];
  assign mac_sum   = sat_add(acc_r[k_q], q_mul(x_q, cur_c));
  assign fin_valid = mac_en && cur_v && cur_l;
  assign fin_idx   = k_q;
  assign tap_cur   = n_q;
  assign busy      = busy_q;
  assign cnt_q     = cnt_r;
  assign overrun   = ovr_q;

  // sample intake, coefficient delay line and sequencer
  always_ff @(posedge clk) begin
    if (!rst_n || win_start) begin
      n_q    <= '0;
      x_q    <= '0;
      line_v <= '0;
      line_l <= '0;
      k_q    <= '0;
      busy_q <= 1'b0;
      cnt_r  <= rst_n ? clamp_cnt(cnt_cfg) : IW'(MIN_OUT);
    end else if (take_evt) begin
      x_q       <= smp_data;
      line_v[0] <= (n_q < NW'(TAPS));
      line_l[0] <= (n_q == NW'(TAPS - 1));
      for (int i = 1; i < MAX_OUT; i++) begin
        line_v[i] <= line_v[i-1];
        line_l[i] <= line_l[i-1];
      end
      if (n_q != N_SAT) n_q <= n_q + NW'(1);
      k_q    <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      k_q    <= k_q + IW'(1);
      busy_q <= (k_q != cnt_r - IW'(1));
    end
  end

  // coefficient values travel with the valid bits (no reset needed)
  always_ff @(posedge clk) begin
    if (take_evt) begin
      line_c[0] <= coef_in;
      for (int i = 1; i < MAX_OUT; i++) line_c[i] <= line_c[i-1];
    end
  end

  // accumulators: one shared multiply-accumulate per clock
  always_ff @(posedge clk) begin
    if (!rst_n || win_start) begin
      for (int i = 0; i < MAX_OUT; i++) acc_r[i] <= '0;
    end else if (mac_en && cur_v) begin
      acc_r[k_q] <= mac_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
  end

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_acc_out
    assign acc_o[g] = acc_r[g];
  end
endmodule

// File: rtl/sfir_result_port.sv
module sfir_result_port import sfir_pkg::*; #(
  parameter int MAX_OUT = SFIR_MAXO,
  parameter int IW      = $clog2(MAX_OUT + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           win_start,
  input  logic                           fin_valid,
  input  logic [IW-1:0]                  fin_idx,
  input  logic [MAX_OUT-1:0][SFIR_W-1:0] acc_i,
  input  logic                           res_ready,
  output logic                           res_valid,
  output logic [SFIR_W-1:0]              res_data,
  output logic [IW-1:0]                  res_idx,
  output logic                           dropped
);
  logic [MAX_OUT-1:0] pend_q, pend_n;
  logic [IW-1:0]      sel;
  logic               found, hs_evt, drop_evt;

  // lowest pending index is presented first
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < MAX_OUT; i++) begin
      if (pend_q[i] && !found) begin
        sel   = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign res_valid = |pend_q;
  assign res_idx   = sel;
  assign res_data  = acc_i[sel];
  assign hs_evt    = res_valid && res_ready && !win_start;
  assign drop_evt  = win_start && res_valid;

  always_comb begin
    pend_n = pend_q;
    if (hs_evt)    pend_n[sel]     = 1'b0;
    if (fin_valid) pend_n[fin_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      dropped <= 1'b0;
    end else if (win_start) begin
      pend_q <= '0;
      if (drop_evt) dropped <= 1'b1;
    end else begin
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/sfir_top.sv
module sfir_top import sfir_pkg::*; #(
  parameter int TAPS    = SFIR_TAPS,
  parameter int MAX_OUT = SFIR_MAXO,
  parameter int MIN_OUT = SFIR_MINO,
  parameter int IW      = $clog2(MAX_OUT + 1),
  parameter int AW      = $clog2(TAPS / 2),
  parameter int NW      = $clog2(TAPS + MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_start,
  input  logic [IW-1:0]     out_count,
  input  logic              cf_we,
  input  logic [AW-1:0]     cf_addr,
  input  logic [SFIR_W-1:0] cf_data,
  input  logic              smp_valid,
  input  logic [SFIR_W-1:0] smp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [SFIR_W-1:0] res_data,
  output logic [IW-1:0]     res_idx,
  output logic              overrun,
  output logic              dropped
);
  logic [NW-1:0]                  tap_cur;
  smp_t                           coef_rd;
  logic                           seq_busy;
  logic                           fin_valid;
  logic [IW-1:0]                  fin_idx;
  logic [IW-1:0]                  cnt_q;
  logic [MAX_OUT-1:0][SFIR_W-1:0] acc_bus;

  sfir_coef_store #(.TAPS(TAPS), .AW(AW), .NW(NW)) u_coef (
    .clk   (clk),
    .we    (cf_we),
    .waddr (cf_addr),
    .wdata (smp_t'(cf_data)),
    .rtap  (tap_cur),
    .rdata (coef_rd)
  );

  sfir_mac_seq #(.TAPS(TAPS), .MAX_OUT(MAX_OUT), .MIN_OUT(MIN_OUT),
                 .IW(IW), .NW(NW)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_start (win_start),
    .smp_valid (smp_valid),
    .smp_data  (smp_t'(smp_data)),
    .cnt_cfg   (out_count),
    .coef_in   (coef_rd),
    .tap_cur   (tap_cur),
    .busy      (seq_busy),
    .fin_valid (fin_valid),
    .fin_idx   (fin_idx),
    .cnt_q     (cnt_q),
    .overrun   (overrun),
    .acc_o     (acc_bus)
  );

  sfir_result_port #(.MAX_OUT(MAX_OUT), .IW(IW)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_start (win_start),
    .fin_valid (fin_valid),
    .fin_idx   (fin_idx),
    .acc_i     (acc_bus),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_idx   (res_idx),
    .dropped   (dropped)
  );
endmodule

// File: rtl/sfir_checker.sv
module sfir_checker import sfir_pkg::*; #(
  parameter int IW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_start,
  input logic              smp_valid,
  input logic              res_valid,
  input logic              res_ready,
  input logic [SFIR_W-1:0] res_data,
  input logic [IW-1:0]     res_idx,
  input logic              overrun,
  input logic              dropped,
  input logic              seq_busy,
  input logic [IW-1:0]     cnt_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!res_valid && !overrun && !dropped));

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_idx < cnt_q));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !win_start) |=>
      (res_valid && $stable(res_data) && $stable(res_idx)));

  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !win_start) |=>
      (!res_valid || (res_idx > $past(res_idx))));

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && seq_busy && !win_start) |=> overrun);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start && res_valid) |=> (dropped && !res_valid));

  assert_win_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> (!seq_busy && !res_valid));
endmodule

bind sfir_top sfir_checker #(.IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_start (win_start),
  .smp_valid (smp_valid),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_idx   (res_idx),
  .overrun   (overrun),
  .dropped   (dropped),
  .seq_busy  (seq_busy),
  .cnt_q     (cnt_q)
);

// File: tb/tb_sfir_top.sv
module tb_sfir_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // vector: {count[3:0], xmode[1:0], cmode[1:0], seed[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {4'd3,  2'd0, 2'd0, 8'd5},   // R3 basic
    {4'd10, 2'd0, 2'd0, 8'd9},   // R3 R7 max outputs
    {4'd0,  2'd0, 2'd0, 8'd13},  // R6 clamp low
    {4'd15, 2'd0, 2'd0, 8'd21},  // R6 clamp high
    {4'd4,  2'd2, 2'd2, 8'd1},   // R4 R5 extreme product, positive limit
    {4'd4,  2'd1, 2'd2, 8'd1},   // R5 negative limit
    {4'd3,  2'd3, 2'd3, 8'd1}    // R4 floor rounding
  };

  logic clk = 0, rst_n = 0, win_start = 0, cf_we = 0, smp_valid = 0, res_ready = 1;
  logic [3:0]  out_count = 4'd3;
  logic [7:0]  cf_addr = '0;
  logic [15:0] cf_data = '0, smp_data = '0;
  logic        res_valid, overrun, dropped;
  logic [15:0] res_data;
  logic [3:0]  res_idx;

  int checks = 0, errors = 0, cap_n = 0;
  int cap_idx [32];
  int cap_dat [32];
  int hc [132];
  int xs [300];
  int expv [10];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfir_top dut (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .out_count(out_count),
    .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_idx(res_idx), .overrun(overrun), .dropped(dropped)
  );

  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready && cap_n < 32) begin
      cap_idx[cap_n] = int'(res_idx);
      cap_dat[cap_n] = int'($signed(res_data));
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int lim(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int refq(input int a, input int b);
    int p, q;
    p = a * b;
    if (p >= 0) q = p / 32768;
    else        q = -((-p + 32767) / 32768);
    return lim(q);
  endfunction

  function automatic int tapc(input int t);
    return (t < 132) ? hc[t] : hc[263 - t];
  endfunction

  function automatic int eff_cnt(input int c);
    return (c < 3) ? 3 : (c > 10) ? 10 : c;
  endfunction

  task automatic load_coefs(input int mode, input int seed);
    for (int i = 0; i < 132; i++) begin
      case (mode)
        0: hc[i] = (((i * (seed + 5) * 29) % 3001) - 1500) * 6;
        1: hc[i] = 32767;
        2: hc[i] = -32768;
        default: hc[i] = 1;
      endcase
      cf_we = 1; cf_addr = 8'(i); cf_data = 16'(hc[i]);
      tick();
    end
    cf_we = 0;
  endtask

  task automatic gen_x(input int mode, input int seed);
    for (int n = 0; n < 300; n++) begin
      case (mode)
        0: xs[n] = (((n * seed * 73 + 11 * seed) % 4001) - 2000) * 8;
        1: xs[n] = 32767;
        2: xs[n] = -32768;
        default: xs[n] = -1;
      endcase
    end
  endtask

  task automatic start_win(input int c);
    win_start = 1; out_count = 4'(c);
    tick();
    win_start = 0;
    cap_n = 0;
  endtask

  task automatic send(input int x);
    smp_valid = 1; smp_data = 16'(x);
    tick();
    smp_valid = 0;
    repeat (11) tick();
  endtask

  task automatic feed(input int from, input int upto);
    for (int n = from; n < upto; n++) send(xs[n]);
  endtask

  task automatic compare(input int c, input string tag);
    int no;
    no = eff_cnt(c);
    for (int k = 0; k < no; k++) begin
      int a;
      a = 0;
      for (int t = 0; t < 264; t++) a = lim(a + refq(xs[k + t], tapc(t)));
      expv[k] = a;
    end
    repeat (20) tick();
    chk(cap_n == no, {tag, " R6 result count"}, cap_n, no);
    for (int k = 0; k < no && k < cap_n; k++) begin
      chk(cap_idx[k] == k, {tag, " R7 order"}, cap_idx[k], k);
      chk(cap_dat[k] == expv[k], {tag, " R3 value"}, cap_dat[k], expv[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(!res_valid && !overrun && !dropped, "R1 during reset", int'(res_valid), 0);
    rst_n = 1;
    tick();
    chk(!res_valid && !overrun && !dropped, "R1 after reset",
        int'({res_valid, overrun, dropped}), 0);

    // table-driven windows (R3 R4 R5 R6 R7)
    for (int v = 0; v < NV; v++) begin
      load_coefs(int'(VEC[v][9:8]), int'(VEC[v][7:0]));
      gen_x(int'(VEC[v][11:10]), int'(VEC[v][7:0]));
      start_win(int'(VEC[v][15:12]));
      feed(0, 273);
      compare(int'(VEC[v][15:12]), $sformatf("vec%0d", v));
    end
    // explicit limit expectations
    chk(expv[0] == -264, "R4 floor of small negative products", expv[0], -264);

    // R2: writes past the stored half are ignored
    load_coefs(0, 5);
    cf_we = 1; cf_addr = 8'd140; cf_data = 16'h7ABC; tick();
    cf_addr = 8'd200; cf_data = 16'h8001; tick();
    cf_we = 0;
    gen_x(0, 7);
    start_win(5);
    feed(0, 273);
    compare(5, "R2 out-of-range write");

    // R9: strobe during busy is ignored and flags overrun
    chk(!overrun, "R9 overrun clear before", int'(overrun), 0);
    gen_x(0, 17);
    start_win(3);
    smp_valid = 1; smp_data = 16'(xs[0]); tick();
    smp_data = 16'd7777; tick();
    smp_valid = 0;
    repeat (11) tick();
    chk(overrun, "R9 overrun set", int'(overrun), 1);
    feed(1, 273);
    compare(3, "R9 ignored sample");
    chk(overrun, "R9 overrun sticky", int'(overrun), 1);

    // R11: window start clears state; simultaneous strobe ignored
    gen_x(0, 31);
    start_win(4);
    for (int n = 0; n < 40; n++) send(12000);
    win_start = 1; out_count = 4'd4; smp_valid = 1; smp_data = 16'd12345;
    tick();
    win_start = 0; smp_valid = 0; cap_n = 0;
    repeat (11) tick();
    feed(0, 273);
    compare(4, "R11 restart");

    // R8 R7 R10: timing of first result, hold, and drop
    gen_x(0, 3);
    res_ready = 0;
    start_win(3);
    feed(0, 263);
    chk(!res_valid, "R8 no result before last tap", int'(res_valid), 0);
    send(xs[263]);
    chk(res_valid && res_idx == 0, "R8 first result after last tap", int'(res_idx), 0);
    begin
      int held;
      held = int'(res_data);
      repeat (5) tick();
      chk(res_valid && int'(res_data) == held, "R7 held while not ready", int'(res_data), held);
    end
    chk(!dropped, "R10 dropped clear before", int'(dropped), 0);
    win_start = 1; tick(); win_start = 0;
    chk(!res_valid, "R10 unread result discarded", int'(res_valid), 0);
    chk(dropped, "R10 dropped flag", int'(dropped), 1);
    res_ready = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule